// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is the station-management master for extended (Clause 45) PHY access over a two-wire MDC/MDIO link. It offers two memory-mapped registers. One holds a 16-bit PHY register number. The other is the management word, which carries the port address, device address, an operation code and write data. It also returns read data, a busy flag and a read-valid flag.

Software loads the register number first. It then writes the management word with a write or read opcode. The block runs two frames on the link. The first is an address frame that places the register number in the PHY. The second is a write frame or a read frame to the same port and device.

MDC comes from a parameterised divider of the system clock and stays low while the block is idle. MDIO is presented as an output value plus an output enable, so a pad tri-state can be built outside the block. The line value comes back on a separate input. During the turnaround and data bits of a read frame the master releases the line. It samples the PHY on rising MDC. The read counts as good only if the PHY pulls the second turnaround bit low.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the MDIO output enable is low.
- R2: Register offset 0x8 holds a 16-bit register number in bits 15:0, and its upper bits read 0. The management word at offset 0x0 is laid out as follows:
  - bits 15:0 hold data;
  - bits 20:16 hold the port address;
  - bits 25:21 hold the device address;
  - bits 28:26 hold the opcode;
  - bit 29 is read-valid;
  - bit 30 is busy;
  - bit 31 reads 0.
- R3: A management write starts an access only if busy is clear and the opcode is 3'b101 (write) or 3'b111 (read). Any other opcode is ignored: busy stays 0, MDC does not toggle and the stored fields are unchanged.
- R4: A management write made while busy is set is ignored. The running frames and the stored port, device and opcode fields are unchanged.
- R5: Each access begins with an address frame, sent MSB first. It is PRE_LEN one-bits of preamble, then start 00, opcode 00, the 5-bit port address, the 5-bit device address, turnaround 10 and the 16-bit register number.
- R6: For a write, a second frame follows. It is preamble, start 00, opcode 01, the same port and device addresses, turnaround 10 and the 16 write-data bits.
- R7: For a read, the second frame is preamble, start 00, opcode 11, port and device addresses. The master then drops its output enable for both turnaround bits and all 16 data bits. It samples the line on rising MDC.
- R8: When a read ends, bits 15:0 take the 16 sampled bits, MSB first. Read-valid is set only if the line was 0 on the second turnaround bit. Read-valid clears when a new access is accepted.
- R9: MDC has a period of 2*CLK_DIV clocks while an access runs and is low while idle. MDIO and its enable change only as MDC falls.
- R10: Busy reads 1 from the first clock after the accepting edge. It clears exactly 2*(PRE_LEN+32)*2*CLK_DIV clock edges after that edge, at the end of the last data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset for writes and reads |
| regWrData | input | 32 | Register write data |
| rdData | output | 32 | Contents of the register selected by regAddr |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value driven by the master |
| mdioOe | output | 1 | MDIO output enable (1 = master drives) |
| mdioIn | input | 1 | MDIO line value as seen at the pad |

## Verification
Every result has a cycle at which it is due. Busy must read 1 at the first clock sample after the accepting edge and 0 exactly 2*(PRE_LEN+32)*2*CLK_DIV edges later. The bench counts falling clock edges from the accept to that boundary and samples one cycle on each side of it. Frame bits are due at each rising MDC. A monitor samples the line at the falling system clock after MDC rose, rebuilds each 32-bit frame, and pops the expected word that the driver queued when it issued the access. The bench PHY presents its turnaround and data bits just after MDC falls, half an MDC period before the master samples them. Read data and read-valid are checked only after busy has cleared.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;
  localparam int REG_W     = 32;
  localparam int FRAME_LEN = 32;
  localparam int MGMT_OFS  = 0;
  localparam int ADDR_OFS  = 8;

  // Field positions in the management word
  localparam int PORT_LSB  = 16;
  localparam int DEV_LSB   = 21;
  localparam int OP_LSB    = 26;
  localparam int VALID_BIT = 29;
  localparam int BUSY_BIT  = 30;

  localparam logic [2:0] OP_WR = 3'b101;
  localparam logic [2:0] OP_RD = 3'b111;

  // Bit indices inside a 32-bit frame
  localparam int TA1_IDX  = 14;
  localparam int TA2_IDX  = 15;
  localparam int DATA_IDX = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_FRAME} seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadData;
    logic shiftOut;
    logic sampleTa;
    logic sampleData;
    logic finish;
  } seqStrobe_t;
endpackage

// File: rtl/mdio_c45_datapath.sv
module mdio_c45_datapath
  import mdio_c45_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  seqStrobe_t        strobe,
  input  logic              mdioIn,
  output logic              accept,
  output logic              busy,
  output logic              rdValid,
  output logic              isRead,
  output logic              frameBit,
  output logic [REG_W-1:0]  rdData
);
  logic [15:0]          regNum;
  logic [4:0]           portQ, devQ;
  logic [2:0]           opQ;
  logic [15:0]          dataQ;
  logic                 busyQ, validQ, taOk;
  logic [15:0]          capQ;
  logic [FRAME_LEN-1:0] shiftQ;

  logic       mgmtSel, addrSel;
  logic [2:0] wrOp;
  logic [4:0] newPort, newDev;
  logic       unusedWrBits;

  assign mgmtSel = (regAddr == ADDR_W'(MGMT_OFS));
  assign addrSel = (regAddr == ADDR_W'(ADDR_OFS));
  assign wrOp    = regWrData[OP_LSB +: 3];
  assign newPort = regWrData[PORT_LSB +: 5];
  assign newDev  = regWrData[DEV_LSB +: 5];
  assign unusedWrBits = ^regWrData[REG_W-1:OP_LSB+3];

  assign accept   = regWrEn && mgmtSel && !busyQ && ((wrOp == OP_WR) || (wrOp == OP_RD));
  assign isRead   = (opQ == OP_RD);
  assign busy     = busyQ;
  assign rdValid  = validQ;
  assign frameBit = shiftQ[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regNum <= '0;
      portQ  <= '0;
      devQ   <= '0;
      opQ    <= '0;
      dataQ  <= '0;
      busyQ  <= 1'b0;
      validQ <= 1'b0;
      taOk   <= 1'b0;
      capQ   <= '0;
      shiftQ <= '1;
    end else begin
      if (regWrEn && addrSel) regNum <= regWrData[15:0];
      if (accept) begin
        portQ  <= newPort;
        devQ   <= newDev;
        opQ    <= wrOp;
        dataQ  <= regWrData[15:0];
        busyQ  <= 1'b1;
        validQ <= 1'b0;
        taOk   <= 1'b0;
        // address frame: start 00, opcode 00, port, device, turnaround 10, register
        shiftQ <= {2'b00, 2'b00, newPort, newDev, 2'b10, regNum};
      end else begin
        if (strobe.loadData)
          shiftQ <= {2'b00, (isRead ? 2'b11 : 2'b01), portQ, devQ, 2'b10,
                     (isRead ? 16'hFFFF : dataQ)};
        else if (strobe.shiftOut)
          shiftQ <= {shiftQ[FRAME_LEN-2:0], 1'b1};
        if (strobe.sampleTa)   taOk <= !mdioIn;
        if (strobe.sampleData) capQ <= {capQ[14:0], mdioIn};
        if (strobe.finish) begin
          busyQ <= 1'b0;
          if (isRead) begin
            validQ <= taOk;
            dataQ  <= capQ;
          end
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (mgmtSel)
      rdData = {1'b0, busyQ, validQ, opQ, devQ, portQ, dataQ};
    else if (addrSel)
      rdData = {16'h0000, regNum};
  end
endmodule

// File: rtl/mdio_c45_ctrl.sv
module mdio_c45_ctrl
  import mdio_c45_pkg::*;
#(
  parameter int CLK_DIV = 5,
  parameter int PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accept,
  input  logic       isRead,
  input  logic       frameBit,
  output seqStrobe_t strobe,
  output logic       mdc,
  output logic       mdioOut,
  output logic       mdioOe
);
  localparam int CNT_MAX = (PRE_LEN > FRAME_LEN) ? PRE_LEN : FRAME_LEN;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  seqState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic [DIV_W-1:0] divCnt;
  logic             mdcQ, dataPhase;
  logic             wrap, riseTick, fallTick, lastPre, lastBit, inFrame, rdPhase;

  assign wrap     = (state != ST_IDLE) && (divCnt == DIV_LAST);
  assign riseTick = wrap && !mdcQ;
  assign fallTick = wrap && mdcQ;
  assign lastPre  = (bitCnt == CNT_W'(PRE_LEN - 1));
  assign lastBit  = (bitCnt == CNT_W'(FRAME_LEN - 1));
  assign inFrame  = (state == ST_FRAME);
  assign rdPhase  = inFrame && dataPhase && isRead;

  always_comb begin
    strobe            = '0;
    strobe.shiftOut   = fallTick && inFrame && !lastBit;
    strobe.loadData   = fallTick && inFrame && lastBit && !dataPhase;
    strobe.finish     = fallTick && inFrame && lastBit && dataPhase;
    strobe.sampleTa   = riseTick && rdPhase && (bitCnt == CNT_W'(TA2_IDX));
    strobe.sampleData = riseTick && rdPhase && (bitCnt >= CNT_W'(DATA_IDX));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      divCnt    <= '0;
      mdcQ      <= 1'b0;
      dataPhase <= 1'b0;
    end else if (state == ST_IDLE) begin
      divCnt <= '0;
      mdcQ   <= 1'b0;
      if (accept) begin
        state     <= ST_PRE;
        bitCnt    <= '0;
        dataPhase <= 1'b0;
      end
    end else begin
      divCnt <= wrap ? '0 : divCnt + 1'b1;
      if (wrap) mdcQ <= !mdcQ;
      if (fallTick) begin
        if (state == ST_PRE) begin
          if (lastPre) begin
            state  <= ST_FRAME;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end else if (lastBit) begin
          bitCnt <= '0;
          if (!dataPhase) begin
            state     <= ST_PRE;
            dataPhase <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign mdc     = mdcQ;
  assign mdioOut = (state == ST_PRE) ? 1'b1 : frameBit;
  always_comb begin
    mdioOe = 1'b0;
    if (state == ST_PRE)
      mdioOe = 1'b1;
    else if (inFrame)
      mdioOe = !(rdPhase && (bitCnt >= CNT_W'(TA1_IDX)));
  end
endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int CLK_DIV = 5,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       rdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  seqStrobe_t strobe;
  logic       accept, busy, rdValid, isRead, frameBit;

  mdio_c45_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .strobe(strobe), .mdioIn(mdioIn),
    .accept(accept), .busy(busy), .rdValid(rdValid), .isRead(isRead),
    .frameBit(frameBit), .rdData(rdData)
  );

  mdio_c45_ctrl #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .accept(accept), .isRead(isRead),
    .frameBit(frameBit), .strobe(strobe), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_c45_sva.sv
module mdio_c45_sva #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              busy,
  input logic              rdValid,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe
);
  logic       mgmtWr;
  logic       goodOp;
  assign mgmtWr = regWrEn && (regAddr == ADDR_W'(0)) && !busy;
  assign goodOp = (regWrData[28:26] == 3'b101) || (regWrData[28:26] == 3'b111);

  // R9: line steady while MDC is high
  a_r9_steady_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));

  // R9: no MDC activity while idle
  a_r9_mdc_low_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R10: an accepted access raises busy
  a_r10_busy_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtWr && goodOp) |=> busy);

  // R3: unknown opcode leaves the block idle
  a_r3_bad_op_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtWr && !goodOp) |=> !busy);

  // R8: read-valid only reported once the access is over
  a_r8_valid_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !busy);
endmodule

bind mdio_c45_master mdio_c45_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .busy(busy), .rdValid(rdValid), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe)
);

// File: tb/mdio_c45_master_tb.sv
module mdio_c45_master_tb;
  localparam int DIV = 2;
  localparam int PRE = 32;
  localparam int AW  = 4;
  localparam int ACCESS_CYC = 2 * (PRE + 32) * 2 * DIV;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   rdData;
  logic          mdc, mdioOut, mdioOe;
  logic          phyOe = 1'b0;
  logic          phyBit = 1'b1;
  logic          line;

  assign line = mdioOe ? mdioOut : (phyOe ? phyBit : 1'b1);

  mdio_c45_master #(.ADDR_W(AW), .CLK_DIV(DIV), .PRE_LEN(PRE)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdData(rdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(line)
  );

  always #10 clk = ~clk;

  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [31:0] expQ[$];
  logic        phyTa = 1'b0;
  logic [15:0] phyData = 16'h0000;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  int          cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic        mdcPrev = 1'b0;
  int          onesRun = 0, bitIdx = 0, lastRise = 0, riseCount = 0;
  int          periodErr = 0, preErr = 0, oeErr = 0, badPeriod = 0, badPre = 0;
  bit          inFrame = 1'b0, rdFrame = 1'b0;
  logic [31:0] word = '0;
  logic [31:0] expWord;

  always @(negedge clk) begin
    if (!rstN) begin
      mdcPrev = 1'b0; onesRun = 0; inFrame = 1'b0; bitIdx = 0;
    end else begin
      if (mdc && !mdcPrev) begin
        riseCount++;
        if ((inFrame || onesRun > 0) && (cyc - lastRise) != 2 * DIV) begin
          periodErr++; badPeriod = cyc - lastRise;
        end
        lastRise = cyc;
        if (!inFrame) begin
          if (line) onesRun++;
          else begin
            if (onesRun != PRE) begin preErr++; badPre = onesRun; end
            inFrame = 1'b1; bitIdx = 1; word = '0; rdFrame = 1'b0; onesRun = 0;
          end
        end else begin
          if (rdFrame && bitIdx >= 14 && mdioOe) oeErr++;
          word = {word[30:0], line};
          bitIdx++;
          if (bitIdx == 4) rdFrame = (word[1:0] == 2'b11);
          if (bitIdx == 32) begin
            inFrame = 1'b0;
            phyOe = 1'b0;
            if (expQ.size() == 0) check(1'b0, "R5 R6 R7 unexpected frame", word, 32'h0);
            else begin
              expWord = expQ.pop_front();
              check(word == expWord, "R5 R6 R7 frame content", word, expWord);
            end
          end
        end
      end
      if (!mdc && mdcPrev && inFrame && rdFrame) begin
        if (bitIdx == 14) phyOe = 1'b0;
        else if (bitIdx == 15) begin phyOe = 1'b1; phyBit = phyTa; end
        else if (bitIdx >= 16 && bitIdx < 32) begin phyOe = 1'b1; phyBit = phyData[31 - bitIdx]; end
      end
      mdcPrev = mdc;
    end
  end

  // ---------------- driver ----------------
  task automatic regWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [AW-1:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic doAccess(input logic [4:0] port, input logic [4:0] dev, input logic [15:0] rnum,
                          input bit rd, input logic [15:0] wdat, input bit midWrite);
    logic [31:0] v;
    regWrite(AW'(8), {16'hFFFF, rnum});
    expQ.push_back({4'b0000, port, dev, 2'b10, rnum});
    expQ.push_back(rd ? {4'b0011, port, dev, 1'b1, phyTa, phyData}
                      : {4'b0001, port, dev, 2'b10, wdat});
    regWrite(AW'(0), {3'b000, (rd ? 3'b111 : 3'b101), dev, port, (rd ? 16'h0000 : wdat)});
    readReg(AW'(0), v);
    check(v[30] == 1'b1, "R10 busy after accept", v, {1'b0, 1'b1, 30'h0});
    check(v[29] == 1'b0, "R8 valid cleared on accept", v, 32'h0);
    if (midWrite) begin
      repeat (100) @(negedge clk);
      regWrite(AW'(0), {3'b000, 3'b111, ~dev, ~port, 16'hBEEF});
      regAddr = '0;
      while (rdData[30]) @(negedge clk);
    end else begin
      repeat (ACCESS_CYC - 1) @(negedge clk);
      readReg(AW'(0), v);
      check(v[30] == 1'b1, "R10 busy still set before last edge", v[30], 32'h1);
      @(negedge clk);
      readReg(AW'(0), v);
      check(v[30] == 1'b0, "R10 busy cleared on schedule", v[30], 32'h0);
    end
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(AW'(0), v); check(v == 32'h0, "R1 mgmt reset", v, 32'h0);
    readReg(AW'(8), v); check(v == 32'h0, "R1 addr reset", v, 32'h0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 link idle", {30'h0, mdc, mdioOe}, 32'h0);

    // R3 unsupported opcode
    regWrite(AW'(0), {3'b000, 3'b010, 5'd4, 5'd3, 16'h1234});
    repeat (40) @(negedge clk);
    readReg(AW'(0), v); check(v == 32'h0, "R3 bad opcode ignored", v, 32'h0);
    check(riseCount == 0, "R3 no MDC activity", riseCount, 32'h0);

    // R2 address register readback
    regWrite(AW'(8), 32'hABCD_5A5A);
    readReg(AW'(8), v); check(v == 32'h0000_5A5A, "R2 addr register", v, 32'h0000_5A5A);

    // R5 R6 write access
    doAccess(5'h11, 5'h1E, 16'h5A5A, 1'b0, 16'h3C96, 1'b0);
    readReg(AW'(0), v);
    check(v == {3'b000, 3'b101, 5'h1E, 5'h11, 16'h3C96}, "R2 mgmt fields after write", v,
          {3'b000, 3'b101, 5'h1E, 5'h11, 16'h3C96});
    check(mdc == 1'b0 && mdioOe == 1'b0, "R9 idle after access", {30'h0, mdc, mdioOe}, 32'h0);

    // R7 R8 good read
    phyTa = 1'b0; phyData = 16'hC3A5;
    doAccess(5'h02, 5'h07, 16'h0100, 1'b1, 16'h0, 1'b0);
    readReg(AW'(0), v);
    check(v == {3'b001, 3'b111, 5'h07, 5'h02, 16'hC3A5}, "R8 read data and valid", v,
          {3'b001, 3'b111, 5'h07, 5'h02, 16'hC3A5});

    // R8 read with no PHY response on turnaround
    phyTa = 1'b1; phyData = 16'h0F0F;
    doAccess(5'h09, 5'h01, 16'h8001, 1'b1, 16'h0, 1'b0);
    readReg(AW'(0), v);
    check(v[29] == 1'b0, "R8 valid low when turnaround not pulled", v[29], 32'h0);
    check(v[15:0] == 16'h0F0F, "R8 sampled data", v[15:0], 32'h0F0F);

    // R4 management write during busy
    doAccess(5'h0A, 5'h15, 16'h1357, 1'b0, 16'hA5A5, 1'b1);
    readReg(AW'(0), v);
    check(v == {3'b000, 3'b101, 5'h15, 5'h0A, 16'hA5A5}, "R4 busy write ignored", v,
          {3'b000, 3'b101, 5'h15, 5'h0A, 16'hA5A5});

    // boundary field values
    phyTa = 1'b0; phyData = 16'h0001;
    doAccess(5'h00, 5'h00, 16'hFFFF, 1'b1, 16'h0, 1'b0);
    readReg(AW'(0), v);
    check(v == {3'b001, 3'b111, 10'h000, 16'h0001}, "R8 read at zero addresses", v,
          {3'b001, 3'b111, 10'h000, 16'h0001});
    doAccess(5'h1F, 5'h1F, 16'h0000, 1'b0, 16'hFFFF, 1'b0);
    readReg(AW'(0), v);
    check(v == {3'b000, 3'b101, 10'h3FF, 16'hFFFF}, "R6 write at full addresses", v,
          {3'b000, 3'b101, 10'h3FF, 16'hFFFF});

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R5 all frames seen", expQ.size(), 32'h0);
    check(periodErr == 0, "R9 MDC period", badPeriod, 2 * DIV);
    check(preErr == 0, "R5 preamble length", badPre, PRE);
    check(oeErr == 0, "R7 master released during read", oeErr, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule